// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of a multi-stream audio controller into one 32-bit interrupt status word and one level-sensitive interrupt line. It holds three groups of sticky status bits: two response-ring flags (response interrupt and overrun), one wake flag per codec address, and a small status byte for each of eight stream descriptors. Producers set these bits with single-cycle pulses. Software clears them by writing ones.

The status word has three parts. One bit per stream mirrors that stream's buffer-completion flag. A controller bit combines the response-ring flags with the codec wake flags that are masked by their wake enables. A summary bit at the top reports that anything at all is pending. The line is registered. It rises only when the global enable in the control word is set and at least one non-summary status bit meets its matching enable bit in the control word.

Top module: `audio_irq_agg`

## Requirements
- R1: Status bit 30 (controller) is 1 whenever response-ring flag bit 0 (response interrupt) or bit 1 (overrun) is set.
- R2: Status bit 30 is also 1 whenever a codec wake flag n is set and wake enable bit n is set. A wake flag whose enable is clear does not raise bit 30.
- R3: Status bit n (n = 0..7) equals bit 2 (buffer completion) of stream n's status byte. Streams 0..3 are the input streams and 4..7 the output streams. Stream bits 3 (FIFO error) and 4 (descriptor error) do not reach the status word.
- R4: Status bit 31 is 1 exactly when any of bits 30..0 is 1.
- R5: The line is a register. After each edge it equals: control bit 31 AND ((status bits 30..0) AND (control bits 30..0)) nonzero, using the values before that edge. Status bit 31 never takes part in this test.
- R6: A codec event with address n (0..14) sets wake flag n. Address 15 changes nothing.
- R7: A write to stream n's status byte clears each of bits 2, 3 and 4 that is written as 1. Bits written as 0 keep their value. The byte always reads bit 5 (FIFO ready) as 1 and bits 0, 1, 6 and 7 as 0, whatever is written.
- R8: The response-ring flags (bit 0 response interrupt, bit 1 overrun) and the 15 wake flags are cleared by writing 1 to the matching bit. A 0 leaves the flag unchanged.
- R9: When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: After reset all flags are 0, the status word is 0, the line is low, and every stream byte reads 0x20.
- R11: A set pulse or clearing write is visible on the flags and the status word right after the edge that samples it. The line follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsp_flag_set_i | input | 1 | Pulse: response-ring interrupt flag event |
| rsp_ovf_set_i | input | 1 | Pulse: response-ring overrun event |
| rsp_clr_we_i | input | 1 | Write strobe for the response-ring flags |
| rsp_clr_data_i | input | 2 | Write-one-to-clear data, bit 0 flag, bit 1 overrun |
| rsp_sts_o | output | 2 | Response-ring flags |
| codec_evt_vld_i | input | 1 | Pulse: codec state change |
| codec_evt_addr_i | input | 4 | Codec address of the state change |
| state_clr_we_i | input | 1 | Write strobe for the wake flags |
| state_clr_data_i | input | 15 | Write-one-to-clear data for the wake flags |
| wake_en_i | input | 15 | Per-codec wake enable |
| state_sts_o | output | 15 | Codec wake flags |
| sd_bcis_set_i | input | 8 | Per-stream buffer-completion pulses |
| sd_fifoe_set_i | input | 8 | Per-stream FIFO-error pulses |
| sd_dese_set_i | input | 8 | Per-stream descriptor-error pulses |
| sd_wr_en_i | input | 8 | Per-stream status-byte write strobe |
| sd_wr_data_i | input | 8 | Shared status-byte write data |
| sd_sts_o | output | 64 | Stream status bytes, stream n at bits 8n+7..8n |
| int_ctl_i | input | 32 | Interrupt control word: bit 31 global enable, others per-source enables |
| int_sts_o | output | 32 | Interrupt status word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The flags and the status word are combinational views of registers, so a pulse or a write takes effect in the first sample after the edge that captures it. The line takes one more edge. The bench drives each stimulus a quarter period after a rising edge and samples every output at that same point after the next edge. It keeps a model of the flags and the status word, updated at each step. The expected line value is computed from the model and the control word as they stood before the step. This puts a one-cycle lag on the line and no lag on everything else.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

  localparam int STS_W    = 32;
  localparam int CTRL_BIT = 30;
  localparam int GLOB_BIT = 31;
  localparam int SD_W     = 8;
  localparam int SD_BCIS  = 2;
  localparam int SD_FIFOE = 3;
  localparam int SD_DESE  = 4;
  localparam int SD_FRDY  = 5;
  localparam int RSP_W    = 2;

  // Packs the three sticky stream flags {dese, fifoe, bcis} into a status byte.
  function automatic logic [SD_W-1:0] sd_pack(input logic [2:0] flags);
    logic [SD_W-1:0] b;
    b = '0;
    b[SD_BCIS]  = flags[0];
    b[SD_FIFOE] = flags[1];
    b[SD_DESE]  = flags[2];
    b[SD_FRDY]  = 1'b1;
    return b;
  endfunction

  // Selects the clearable stream bits of a written byte, as {dese, fifoe, bcis}.
  function automatic logic [2:0] sd_clear_mask(input logic [SD_W-1:0] wdata);
    return {wdata[SD_DESE], wdata[SD_FIFOE], wdata[SD_BCIS]};
  endfunction

  // Builds the status word from the controller hit and the per-stream bits.
  function automatic logic [STS_W-1:0] fold_sts(input logic ctrl_hit,
                                                 input logic [CTRL_BIT-1:0] strm);
    logic [STS_W-1:0] s;
    s = STS_W'(strm);
    s[CTRL_BIT] = ctrl_hit;
    s[GLOB_BIT] = |s[GLOB_BIT-1:0];
    return s;
  endfunction

  // Next value of the interrupt line: the summary bit is left out of the test.
  function automatic logic line_next(input logic [STS_W-1:0] sts,
                                     input logic [STS_W-1:0] ctl);
    logic [STS_W-1:0] eligible;
    eligible = sts & ~(STS_W'(1) << GLOB_BIT);
    return ctl[GLOB_BIT] && ((eligible & ctl) != '0);
  endfunction

endpackage

// File: rtl/irq_w1c_bits.sv
module irq_w1c_bits #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_data_i : '0;

  // A set pulse overrides a clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_mask) | set_i;
  end

endmodule

// File: rtl/irq_codec_state.sv
module irq_codec_state #(
  parameter int NUM_CODEC = 15,
  parameter int CAD_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_vld_i,
  input  logic [CAD_W-1:0]     evt_addr_i,
  input  logic                 clr_we_i,
  input  logic [NUM_CODEC-1:0] clr_data_i,
  input  logic [NUM_CODEC-1:0] wake_en_i,
  output logic [NUM_CODEC-1:0] state_o,
  output logic                 wake_hit_o
);

  logic [NUM_CODEC-1:0] evt_onehot;

  // Addresses at or above NUM_CODEC decode to no bit.
  for (genvar c = 0; c < NUM_CODEC; c++) begin : g_dec
    assign evt_onehot[c] = evt_vld_i && (evt_addr_i == CAD_W'(c));
  end

  irq_w1c_bits #(.W(NUM_CODEC)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_onehot),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .q_o        (state_o)
  );

  assign wake_hit_o = |(state_o & wake_en_i);

endmodule

// File: rtl/irq_stream_bank.sv
module irq_stream_bank
  import audio_irq_pkg::*;
#(
  parameter int NUM_STRM = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_STRM-1:0]      bcis_set_i,
  input  logic [NUM_STRM-1:0]      fifoe_set_i,
  input  logic [NUM_STRM-1:0]      dese_set_i,
  input  logic [NUM_STRM-1:0]      wr_en_i,
  input  logic [SD_W-1:0]          wr_data_i,
  output logic [NUM_STRM*SD_W-1:0] sts_o,
  output logic [NUM_STRM-1:0]      bcis_o
);

  logic [2:0] clr_bits;

  assign clr_bits = sd_clear_mask(wr_data_i);

  for (genvar n = 0; n < NUM_STRM; n++) begin : g_strm
    logic [2:0] flags;

    irq_w1c_bits #(.W(3)) u_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      ({dese_set_i[n], fifoe_set_i[n], bcis_set_i[n]}),
      .clr_we_i   (wr_en_i[n]),
      .clr_data_i (clr_bits),
      .q_o        (flags)
    );

    assign sts_o[n*SD_W +: SD_W] = sd_pack(flags);
    assign bcis_o[n]             = flags[0];
  end

endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import audio_irq_pkg::*;
#(
  parameter int NUM_STRM = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RSP_W-1:0]    rsp_sts_i,
  input  logic                wake_hit_i,
  input  logic [NUM_STRM-1:0] bcis_i,
  input  logic [STS_W-1:0]    int_ctl_i,
  output logic [STS_W-1:0]    int_sts_o,
  output logic                irq_o
);

  logic ctrl_hit;
  logic irq_d;

  assign ctrl_hit  = (|rsp_sts_i) | wake_hit_i;
  assign int_sts_o = fold_sts(ctrl_hit, CTRL_BIT'(bcis_i));
  assign irq_d     = line_next(int_sts_o, int_ctl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end

endmodule

// File: rtl/audio_irq_agg.sv
module audio_irq_agg
  import audio_irq_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 4,
  parameter int NUM_CODEC = 15,
  parameter int CAD_W     = 4,
  localparam int NUM_STRM = NUM_IN + NUM_OUT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rsp_flag_set_i,
  input  logic                     rsp_ovf_set_i,
  input  logic                     rsp_clr_we_i,
  input  logic [RSP_W-1:0]         rsp_clr_data_i,
  output logic [RSP_W-1:0]         rsp_sts_o,
  input  logic                     codec_evt_vld_i,
  input  logic [CAD_W-1:0]         codec_evt_addr_i,
  input  logic                     state_clr_we_i,
  input  logic [NUM_CODEC-1:0]     state_clr_data_i,
  input  logic [NUM_CODEC-1:0]     wake_en_i,
  output logic [NUM_CODEC-1:0]     state_sts_o,
  input  logic [NUM_STRM-1:0]      sd_bcis_set_i,
  input  logic [NUM_STRM-1:0]      sd_fifoe_set_i,
  input  logic [NUM_STRM-1:0]      sd_dese_set_i,
  input  logic [NUM_STRM-1:0]      sd_wr_en_i,
  input  logic [SD_W-1:0]          sd_wr_data_i,
  output logic [NUM_STRM*SD_W-1:0] sd_sts_o,
  input  logic [STS_W-1:0]         int_ctl_i,
  output logic [STS_W-1:0]         int_sts_o,
  output logic                     irq_o
);

  logic                wake_hit;
  logic [NUM_STRM-1:0] strm_bcis;

  // Response-ring flags: bit 0 response interrupt, bit 1 overrun.
  irq_w1c_bits #(.W(RSP_W)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      ({rsp_ovf_set_i, rsp_flag_set_i}),
    .clr_we_i   (rsp_clr_we_i),
    .clr_data_i (rsp_clr_data_i),
    .q_o        (rsp_sts_o)
  );

  irq_codec_state #(.NUM_CODEC(NUM_CODEC), .CAD_W(CAD_W)) u_codec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_vld_i  (codec_evt_vld_i),
    .evt_addr_i (codec_evt_addr_i),
    .clr_we_i   (state_clr_we_i),
    .clr_data_i (state_clr_data_i),
    .wake_en_i  (wake_en_i),
    .state_o    (state_sts_o),
    .wake_hit_o (wake_hit)
  );

  irq_stream_bank #(.NUM_STRM(NUM_STRM)) u_strm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bcis_set_i  (sd_bcis_set_i),
    .fifoe_set_i (sd_fifoe_set_i),
    .dese_set_i  (sd_dese_set_i),
    .wr_en_i     (sd_wr_en_i),
    .wr_data_i   (sd_wr_data_i),
    .sts_o       (sd_sts_o),
    .bcis_o      (strm_bcis)
  );

  irq_combine #(.NUM_STRM(NUM_STRM)) u_comb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rsp_sts_i  (rsp_sts_o),
    .wake_hit_i (wake_hit),
    .bcis_i     (strm_bcis),
    .int_ctl_i  (int_ctl_i),
    .int_sts_o  (int_sts_o),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/audio_irq_agg_chk.sv
module audio_irq_agg_chk #(
  parameter int NUM_STRM  = 8,
  parameter int NUM_CODEC = 15,
  parameter int CAD_W     = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            rsp_sts_o,
  input logic                  codec_evt_vld_i,
  input logic [CAD_W-1:0]      codec_evt_addr_i,
  input logic [NUM_CODEC-1:0]  wake_en_i,
  input logic [NUM_CODEC-1:0]  state_sts_o,
  input logic [NUM_STRM-1:0]   sd_bcis_set_i,
  input logic [NUM_STRM-1:0]   sd_wr_en_i,
  input logic [7:0]            sd_wr_data_i,
  input logic [NUM_STRM*8-1:0] sd_sts_o,
  input logic [31:0]           int_ctl_i,
  input logic [31:0]           int_sts_o,
  input logic                  irq_o
);

  p_ctrl_rsp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_sts_o != 2'b00) |-> int_sts_o[30]);

  p_ctrl_wake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_sts_o & wake_en_i) != '0) |-> int_sts_o[30]);

  p_ctrl_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rsp_sts_o == 2'b00) && ((state_sts_o & wake_en_i) == '0)) |-> !int_sts_o[30]);

  p_global_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(int_sts_o[31]));

  p_line_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(int_ctl_i[31]));

  for (genvar n = 0; n < NUM_STRM; n++) begin : g_strm_chk
    p_strm_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_sts_o[n] == sd_sts_o[n*8+2]);

    p_w1c_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni && sd_wr_en_i[n] && sd_wr_data_i[2] && !sd_bcis_set_i[n])
      |-> !sd_sts_o[n*8+2]);

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni && sd_bcis_set_i[n]) |-> sd_sts_o[n*8+2]);
  end

  for (genvar c = 0; c < NUM_CODEC; c++) begin : g_codec_chk
    p_codec_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni && codec_evt_vld_i && (codec_evt_addr_i == CAD_W'(c)))
      |-> state_sts_o[c]);
  end

endmodule

bind audio_irq_agg audio_irq_agg_chk #(
  .NUM_STRM  (NUM_IN + NUM_OUT),
  .NUM_CODEC (NUM_CODEC),
  .CAD_W     (CAD_W)
) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .rsp_sts_o        (rsp_sts_o),
  .codec_evt_vld_i  (codec_evt_vld_i),
  .codec_evt_addr_i (codec_evt_addr_i),
  .wake_en_i        (wake_en_i),
  .state_sts_o      (state_sts_o),
  .sd_bcis_set_i    (sd_bcis_set_i),
  .sd_wr_en_i       (sd_wr_en_i),
  .sd_wr_data_i     (sd_wr_data_i),
  .sd_sts_o         (sd_sts_o),
  .int_ctl_i        (int_ctl_i),
  .int_sts_o        (int_sts_o),
  .irq_o            (irq_o)
);

// File: tb/audio_irq_agg_tb_top.sv
module audio_irq_agg_tb_top;

  localparam int CLK_P   = 10;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rsp_flag_set, rsp_ovf_set, rsp_clr_we;
  logic [1:0]  rsp_clr_data, rsp_sts;
  logic        evt_vld;
  logic [3:0]  evt_addr;
  logic        st_clr_we;
  logic [14:0] st_clr_data, wake_en, state_sts;
  logic [7:0]  bcis_set, fifoe_set, dese_set, sd_we, sd_wd;
  logic [63:0] sd_sts;
  logic [31:0] int_ctl, int_sts;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Bench model of the flags: {dese, fifoe, bcis} per stream.
  logic [1:0]  m_rsp;
  logic [14:0] m_state;
  logic [2:0]  m_sd [8];
  logic        exp_irq;

  always #(CLK_P/2) clk = ~clk;

  audio_irq_agg dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .rsp_flag_set_i   (rsp_flag_set),
    .rsp_ovf_set_i    (rsp_ovf_set),
    .rsp_clr_we_i     (rsp_clr_we),
    .rsp_clr_data_i   (rsp_clr_data),
    .rsp_sts_o        (rsp_sts),
    .codec_evt_vld_i  (evt_vld),
    .codec_evt_addr_i (evt_addr),
    .state_clr_we_i   (st_clr_we),
    .state_clr_data_i (st_clr_data),
    .wake_en_i        (wake_en),
    .state_sts_o      (state_sts),
    .sd_bcis_set_i    (bcis_set),
    .sd_fifoe_set_i   (fifoe_set),
    .sd_dese_set_i    (dese_set),
    .sd_wr_en_i       (sd_we),
    .sd_wr_data_i     (sd_wd),
    .sd_sts_o         (sd_sts),
    .int_ctl_i        (int_ctl),
    .int_sts_o        (int_sts),
    .irq_o            (irq)
  );

  function automatic logic [31:0] exp_sts();
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 8; n++) s[n] = m_sd[n][0];
    s[30] = (m_rsp != 0) || ((m_state & wake_en) != 0);
    s[31] = (s[30:0] != 0);
    return s;
  endfunction

  function automatic logic [63:0] exp_sd();
    logic [63:0] v;
    for (int n = 0; n < 8; n++)
      v[n*8 +: 8] = {2'b00, 1'b1, m_sd[n][2], m_sd[n][1], m_sd[n][0], 2'b00};
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] e;
    e = exp_sts();
    chk("R3 stream bits", 64'(int_sts[7:0]), 64'(e[7:0]));
    chk("R1 R2 controller bit", 64'(int_sts[30]), 64'(e[30]));
    chk("R4 summary bit", 64'(int_sts[31]), 64'(e[31]));
    chk("R4 unused bits zero", 64'(int_sts[29:8]), 64'd0);
    chk("R5 line", 64'(irq), 64'(exp_irq));
    chk("R6 wake flags", 64'(state_sts), 64'(m_state));
    chk("R7 stream bytes", sd_sts, exp_sd());
    chk("R8 response flags", 64'(rsp_sts), 64'(m_rsp));
  endtask

  task automatic clear_stim();
    rsp_flag_set = 0; rsp_ovf_set = 0; rsp_clr_we = 0; rsp_clr_data = 0;
    evt_vld = 0; evt_addr = 0; st_clr_we = 0; st_clr_data = 0;
    bcis_set = 0; fifoe_set = 0; dese_set = 0; sd_we = 0; sd_wd = 0;
  endtask

  // One clock step: model update (set beats clear), edge, then checks.
  task automatic tick();
    logic [31:0] s;
    logic        nxt;
    logic [1:0]  rclr;
    logic [14:0] sclr;
    s   = exp_sts();
    nxt = int_ctl[31] && (((s & 32'h7FFF_FFFF) & int_ctl) != 0);
    rclr = rsp_clr_we ? rsp_clr_data : 2'b00;
    m_rsp = (m_rsp & ~rclr) | {rsp_ovf_set, rsp_flag_set};
    sclr = st_clr_we ? st_clr_data : 15'd0;
    m_state = m_state & ~sclr;
    if (evt_vld && evt_addr < 4'd15) m_state[evt_addr] = 1'b1;
    for (int n = 0; n < 8; n++) begin
      logic [2:0] c;
      c = sd_we[n] ? {sd_wd[4], sd_wd[3], sd_wd[2]} : 3'b000;
      m_sd[n] = (m_sd[n] & ~c) | {dese_set[n], fifoe_set[n], bcis_set[n]};
    end
    @(posedge clk);
    #(CLK_P/4);
    exp_irq = nxt;
    clear_stim();
    check_all();
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT && !done) begin
        fails++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    clear_stim();
    rst_n = 0; wake_en = 0; int_ctl = 0;
    m_rsp = 0; m_state = 0; exp_irq = 0;
    for (int n = 0; n < 8; n++) m_sd[n] = 3'b000;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R10: reset values.
    chk("R10 status word", 64'(int_sts), 64'd0);
    chk("R10 line", 64'(irq), 64'd0);
    chk("R10 stream bytes", sd_sts, {8{8'h20}});
    chk("R10 flags", 64'({rsp_sts, state_sts}), 64'd0);
    rst_n = 1;
    tick();

    // Codec addresses 0..15, enabled and disabled wake.
    int_ctl = 32'hC000_0000;
    for (int a = 0; a < 16; a++) begin
      wake_en = (a < 15) ? 15'(1 << a) : 15'h7FFF;
      evt_vld = 1; evt_addr = 4'(a);
      tick();
      wake_en = 0;
      tick();
      st_clr_we = 1; st_clr_data = (a < 15) ? 15'(1 << a) : 15'h7FFF;
      tick();
    end
    // Wake flags: partial clears leave the rest.
    for (int a = 0; a < 15; a++) begin
      evt_vld = 1; evt_addr = 4'(a); tick();
    end
    wake_en = 15'h0101;
    st_clr_we = 1; st_clr_data = 15'h00FF; tick();
    st_clr_we = 1; st_clr_data = 15'h0000; tick();
    st_clr_we = 1; st_clr_data = 15'h7F00; tick();

    // Response-ring flags: every set pattern against every clear pattern.
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        rsp_flag_set = p[0]; rsp_ovf_set = p[1]; tick();
        rsp_clr_we = 1; rsp_clr_data = 2'(q); tick();
        rsp_clr_we = 1; rsp_clr_data = 2'b11; tick();
      end
    end

    // Stream bytes: every write value on every stream.
    for (int s = 0; s < 8; s++) begin
      int_ctl = 32'h8000_0000 | (32'h1 << s);
      for (int w = 0; w < 256; w++) begin
        bcis_set[s] = 1; fifoe_set[s] = 1; dese_set[s] = 1; tick();
        sd_we[s] = 1; sd_wd = 8'(w); tick();
      end
      sd_we[s] = 1; sd_wd = 8'hFF; tick();
    end
    // Errors alone do not reach the status word (R3).
    fifoe_set = 8'hFF; dese_set = 8'hFF; tick();
    chk("R3 errors excluded", 64'(int_sts), 64'd0);
    sd_we = 8'hFF; sd_wd = 8'hFF; tick();

    // Control word sweep with several sources pending (R5).
    bcis_set = 8'h28; rsp_flag_set = 1; tick();
    for (int k = 0; k < 256; k++) begin
      int_ctl = {k[0], k[1], 22'd0, 8'(k * 37)};
      tick();
    end
    int_ctl = 32'h8000_0000; tick(); tick();
    chk("R5 summary bit not an enable", 64'(irq), 64'd0);
    int_ctl = 32'h7FFF_FFFF; tick(); tick();
    chk("R5 global enable off", 64'(irq), 64'd0);

    // R11 timing: status the same step, line one step later.
    rsp_clr_we = 1; rsp_clr_data = 2'b11; sd_we = 8'hFF; sd_wd = 8'hFF;
    int_ctl = 32'hFFFF_FFFF; tick(); tick();
    bcis_set[6] = 1; tick();
    chk("R11 status bit same step", 64'(int_sts[6]), 64'd1);
    chk("R11 line not yet", 64'(irq), 64'd0);
    tick();
    chk("R11 line one step later", 64'(irq), 64'd1);

    // R9: set and clear on the same bit in the same cycle.
    bcis_set[1] = 1; sd_we[1] = 1; sd_wd = 8'h04; tick();
    chk("R9 stream set wins", 64'(sd_sts[10]), 64'd1);
    evt_vld = 1; evt_addr = 4'd9; st_clr_we = 1; st_clr_data = 15'h7FFF; tick();
    chk("R9 wake set wins", 64'(state_sts[9]), 64'd1);
    rsp_ovf_set = 1; rsp_clr_we = 1; rsp_clr_data = 2'b10; tick();
    chk("R9 overrun set wins", 64'(rsp_sts[1]), 64'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule